// File: doc/BRIEF.md
# Sticky Aggregated Interrupt Controller

This block gathers a vector of interrupt source events into one request flag per source and drives a single combined interrupt line. Every flag is sticky. An event sets its flag, and only software can clear it, by writing a one to that bit on the clear port. Taking the interrupt does not clear anything.

The combined line is a one-clock pulse. It fires only when a new enabled event arrives while every enabled flag is still clear. Software therefore has to clear all enabled flags before the line can fire again. A flag whose enable bit is 0 still records its events, but it neither triggers the line nor blocks it. The enable vector selects which sources take part in that decision and nothing else.

Top module: `sirq_aggregator`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag and `irq_o` are 0 after that edge.
- R2: An event bit at 1 on a clock edge makes the matching flag 1 after that edge, whatever its enable bit. A flag never becomes 1 without an event.
- R3: A flag at 1 stays at 1 on every edge where its clear bit is 0.
- R4: A clear bit at 1 without an event on the same bit makes that flag 0 after the edge. A clear bit at 0 has no effect.
- R5: When the event and clear bits of the same source are both 1 on an edge, the flag is 1 after that edge.
- R6: `irq_o` is 1 for exactly the cycle after an edge at which at least one bit of `evt_i & en_i` is 1 and every bit of `flags_o & en_i` is 0. In every other cycle it is 0.
- R7: No pulse is made while any enabled flag is 1. This includes further events on a source whose flag is already set.
- R8: Flags whose enable bit is 0 neither block the pulse nor cause one.
- R9: Setting an enable bit from 0 to 1 while its flag is already 1 produces no pulse.
- R10: Several enabled events on the same edge, with no enabled flag set, give one single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_SRC | Source event per bit, sampled every edge |
| en_i | input | NUM_SRC | Per-source enable for the combined line |
| clr_i | input | NUM_SRC | Write-one-to-clear strobe per flag |
| flags_o | output | NUM_SRC | Sticky request flags |
| irq_o | output | 1 | One-cycle combined interrupt pulse |

## Verification
The assertions treat the three input vectors as fully free. They assume only that the inputs are stable around each rising edge. They state no rule about how the enable bits relate to the events or the clears, so enable changes, clears and events may land on the same edge. The stimulus changes all inputs shortly after each rising edge. It then runs a directed sequence through the set-while-set, clear-versus-event, masked-flag and late-enable cases, followed by a long phase of random vectors. That random phase is biased so that the enabled set often becomes empty again and the pulse condition keeps recurring.

// File: rtl/sirq_pkg.sv
// Package: shared constants for the sticky interrupt aggregator.
// Assumes nothing; only supplies the default source count.
package sirq_pkg;
    localparam int SIRQ_DEFAULT_SRC = 8;
endpackage

// File: rtl/sirq_flag_cell.sv
// Module: one sticky request flag.
// Set by an event, cleared by a write-one strobe; the event wins a tie.
// Assumes synchronous active-low reset.
module sirq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    // Hold, set or clear the flag on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (evt)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sirq_pulse_gen.sv
// Module: combined interrupt pulse generator.
// Emits one pulse when an enabled event arrives while all enabled flags are 0.
// Assumes flags is the registered flag vector ahead of this edge's update.
module sirq_pulse_gen #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] evt,
    output logic               irq
);
    logic armed;
    logic fresh;

    // The line is armed only while the enabled flag set is empty.
    always_comb armed = ~|(flags & en);
    // A fresh enabled event is one that the enable lets through.
    always_comb fresh = |(evt & en);

    // Register the pulse so that it lines up with the flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= armed & fresh;
    end
endmodule

// File: rtl/sirq_aggregator.sv
// Module: sticky aggregated interrupt controller (top).
// Holds one sticky flag per source and one combined one-cycle pulse.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module sirq_aggregator
    import sirq_pkg::*;
#(
    parameter int NUM_SRC = SIRQ_DEFAULT_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] flag_q;

    // One flag cell per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        sirq_flag_cell i_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt_i[g]),
            .clr  (clr_i[g]),
            .flag (flag_q[g])
        );
    end

    sirq_pulse_gen #(.NUM_SRC(NUM_SRC)) i_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .flags(flag_q),
        .en   (en_i),
        .evt  (evt_i),
        .irq  (irq_o)
    );

    // Flags leave the block as they are stored.
    always_comb flags_o = flag_q;
endmodule

// File: rtl/sirq_aggregator_chk.sv
// Module: property checker for sirq_aggregator, attached by bind.
// Assumes the same clock and synchronous active-low reset as the top.
module sirq_aggregator_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic [NUM_SRC-1:0] clr_i,
    input logic [NUM_SRC-1:0] flags_o,
    input logic               irq_o
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i))); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & ~$past(flags_o | evt_i)) == '0)); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_o & ~clr_i)) |=> ((flags_o & $past(flags_o & ~clr_i)) == $past(flags_o & ~clr_i))); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((flags_o & $past(clr_i & ~evt_i)) == '0)); // R4
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (($past(flags_o & en_i) == '0) && ($past(evt_i & en_i) != '0))); // R6
    AST_PULSE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & en_i) != '0) |=> !irq_o); // R7
endmodule

bind sirq_aggregator sirq_aggregator_chk #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .en_i   (en_i),
    .clr_i  (clr_i),
    .flags_o(flags_o),
    .irq_o  (irq_o)
);

// File: tb/test_sirq_aggregator.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module test_sirq_aggregator;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic [N-1:0] en = '0;
    logic [N-1:0] clr = '0;
    logic [N-1:0] flags_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit [N-1:0] m_flags = '0;
    bit         m_irq = 1'b0;

    sirq_aggregator #(.NUM_SRC(N)) i_sirq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .clr_i(clr),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // Reference model: derived from the requirements, one step per edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0;
            m_irq   = 1'b0;
        end else begin
            m_irq = ((m_flags & en) == '0) && ((evt & en) != '0);
            for (int i = 0; i < N; i++) begin
                if (evt[i]) m_flags[i] = 1'b1;
                else if (clr[i]) m_flags[i] = 1'b0;
            end
        end
    end

    // Compare against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (flags_o !== m_flags || irq_o !== m_irq) begin
                errors++;
                $display("FAIL model R2/R6: flags=%h irq=%b expected flags=%h irq=%b",
                         flags_o, irq_o, m_flags, m_irq);
            end
        end
    end

    task automatic check(input string req, input logic [N-1:0] f, input logic q);
        checks++;
        if (flags_o !== f || irq_o !== q) begin
            errors++;
            $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b",
                     req, flags_o, irq_o, f, q);
        end
    endtask

    // Apply one set of inputs and let one edge consume them.
    task automatic cyc(input logic [N-1:0] e, input logic [N-1:0] n, input logic [N-1:0] c);
        evt = e; en = n; clr = c;
        @(posedge clk); #2;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        evt = 8'hFF; en = 8'hFF; clr = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", 8'h00, 1'b0);
        rst_n = 1'b1;
        cyc(8'h00, 8'hFF, 8'h00);
        check("R1 idle", 8'h00, 1'b0);
        cyc(8'h01, 8'h01, 8'h00);
        check("R2 R6 first event", 8'h01, 1'b1);
        cyc(8'h00, 8'h01, 8'h00);
        check("R3 R6 single pulse", 8'h01, 1'b0);
        cyc(8'h01, 8'h01, 8'h00);
        check("R7 repeat event", 8'h01, 1'b0);
        cyc(8'h02, 8'h03, 8'h00);
        check("R7 other source", 8'h03, 1'b0);
        cyc(8'h00, 8'h03, 8'h00);
        check("R4 zero clear no effect", 8'h03, 1'b0);
        cyc(8'h00, 8'h03, 8'h03);
        check("R4 clear", 8'h00, 1'b0);
        cyc(8'h04, 8'h03, 8'h00);
        check("R8 disabled event", 8'h04, 1'b0);
        cyc(8'h08, 8'h08, 8'h00);
        check("R8 disabled flag ignored", 8'h0C, 1'b1);
        cyc(8'h00, 8'h08, 8'h08);
        check("R4 partial clear", 8'h04, 1'b0);
        cyc(8'h00, 8'h0C, 8'h00);
        check("R9 late enable", 8'h04, 1'b0);
        cyc(8'h00, 8'h00, 8'hFF);
        check("R4 clear all", 8'h00, 1'b0);
        cyc(8'h30, 8'h30, 8'h10);
        check("R5 R10 tie and multi", 8'h30, 1'b1);
        cyc(8'h00, 8'h30, 8'h00);
        check("R10 one pulse", 8'h30, 1'b0);
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] re, rn, rc;
            re = $urandom & $urandom & $urandom;
            rn = $urandom;
            rc = ($urandom % 3 == 0) ? 8'hFF : $urandom;
            cyc(re, rn, rc);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule